// File: doc/BRIEF.md
# Vector Operand Swizzle and Write-Mask Unit

This block sits in front of a four-lane vector ALU and prepares its operands. Up to three source vectors, each four lanes of 24-bit floating-point words already read from the register files, are reordered lane by lane and optionally sign-flipped, under control of an operand descriptor. The descriptor also carries a four-bit lane-enable mask that becomes the per-lane write enables of the destination. Descriptors live in a small internal table with one write port and are picked per instruction by a descriptor ID.

The unit also resolves relative register addressing. An instruction names one of three offset sources (two address registers or the loop counter), or none, and the selected signed offset is added to the register index of either the first or the second source, depending on whether the instruction uses the inverted operand encoding. The destination index is decoded into an output-register file, a temporary-register file or a discarded write.

Apart from the descriptor table, the whole path is combinational: a descriptor written on one clock edge is visible at the outputs from the next cycle on. The arithmetic and the register files are outside this block.

Top module: `swzOperandUnit`

## Requirements
- R1: Source vector s occupies bits [96s+95:96s] of `srcData`, and its component c (0=x, 1=y, 2=z, 3=w) is bits [24c+23:24c] of that slice; the same layout applies to `srcOut`. Output lane i of source s carries the input component named by that source's 2-bit selector for lane i.
- R2: When a source's negate bit is set, bit 23 (the sign) of each of its four output lanes is inverted after selection and the other 23 bits are unchanged.
- R3: The three sources are selected and negated independently, each by its own selectors and negate bit.
- R4: Descriptor layout: bits [3:0] are the lane-enable mask (bit i for lane i); for source s the negate bit is bit 4+9s and the selector of lane i is bits [6+9s+2i:5+9s+2i]. Destination write enables are raised only for lanes whose mask bit is set.
- R5: A destination index below 16 drives `outWrEn` with the mask, 16 to 31 drives `tmpWrEn` with the mask, and 32 or above raises neither; `dstReg` gives the register number within the chosen file (index, or index minus 16).
- R6: `addrRegSel` 0 applies no offset; 1, 2 and 3 apply `addrReg0`, `addrReg1` and `loopCount` (signed 8-bit) respectively. The effective index is the sum modulo 128.
- R7: With `invertedEnc` low the offset is added to the first source index only; with it high it is added to the second source index only.
- R8: A table write with `descWrEn` high stores `descWrData` at `descWrAddr` on the rising edge and is read from the next cycle via `descId`; with `descWrEn` low the table is unchanged, and writing one entry leaves the others unchanged.
- R9: Reset clears every descriptor to zero, so an unwritten entry broadcasts component x to all lanes without negation and enables no lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| descWrEn | input | 1 | Descriptor table write strobe |
| descWrAddr | input | 7 | Table entry to write |
| descWrData | input | 31 | Descriptor to store |
| descId | input | 7 | Descriptor selected for the current instruction |
| invertedEnc | input | 1 | Instruction uses inverted operand encoding |
| addrRegSel | input | 2 | Offset source: none, address reg 0, address reg 1, loop counter |
| addrReg0 | input | 8 | Address register 0 (signed) |
| addrReg1 | input | 8 | Address register 1 (signed) |
| loopCount | input | 8 | Loop counter (signed) |
| src1Idx | input | 7 | First source register index |
| src2Idx | input | 7 | Second source register index |
| dstIdx | input | 7 | Destination register index |
| srcData | input | 288 | Three raw four-lane source vectors |
| src1IdxEff | output | 7 | First source index after offset |
| src2IdxEff | output | 7 | Second source index after offset |
| srcOut | output | 288 | Swizzled and negated source vectors |
| dstReg | output | 4 | Register number within the destination file |
| outWrEn | output | 4 | Per-lane write enables, output-register file |
| tmpWrEn | output | 4 | Per-lane write enables, temporary file |

## Verification
The assertions take the inputs to be known and held steady around each rising edge once reset is released, and take the descriptor write strobe to be low during reset so that the first post-reset table check sees no stale write. The bench changes every input on the falling edge, holds the write strobe low throughout reset, and reads combinational results a nanosecond after its own input change, well before the next rising edge. The sweeps cover all 256 selector patterns for each source with varied negate bits and masks, every destination index, and every offset source under both encodings with indices chosen to wrap.

// File: rtl/swzPkg.sv
package swzPkg;
  localparam int NSRC   = 3;
  localparam int LANES  = 4;
  localparam int SEL_W  = $clog2(LANES);
  localparam int FLD_W  = 1 + LANES * SEL_W;
  localparam int DESC_W = LANES + NSRC * FLD_W;

  // Strobes from control to datapath
  typedef struct packed {
    logic [NSRC-1:0]                        negate;
    logic [NSRC-1:0][LANES-1:0][SEL_W-1:0]  laneSel;
    logic [LANES-1:0]                       laneMask;
  } swzStrobe_t;
endpackage

// File: rtl/swzCtrl.sv
module swzCtrl
  import swzPkg::*;
#(
  parameter int DEPTH    = 128,
  parameter int IDX_W    = 7,
  parameter int OFF_W    = 8,
  parameter int DST_W    = 7,
  parameter int OUT_REGS = 16,
  parameter int TMP_REGS = 16,
  localparam int AW      = $clog2(DEPTH),
  localparam int REG_W   = $clog2(OUT_REGS)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    descWrEn,
  input  logic [AW-1:0]           descWrAddr,
  input  logic [DESC_W-1:0]       descWrData,
  input  logic [AW-1:0]           descId,
  input  logic                    invertedEnc,
  input  logic [1:0]              addrRegSel,
  input  logic signed [OFF_W-1:0] addrReg0,
  input  logic signed [OFF_W-1:0] addrReg1,
  input  logic signed [OFF_W-1:0] loopCount,
  input  logic [IDX_W-1:0]        src1Idx,
  input  logic [IDX_W-1:0]        src2Idx,
  input  logic [DST_W-1:0]        dstIdx,
  output swzStrobe_t              strobe,
  output logic [IDX_W-1:0]        src1IdxEff,
  output logic [IDX_W-1:0]        src2IdxEff,
  output logic [REG_W-1:0]        dstReg,
  output logic [LANES-1:0]        outWrEn,
  output logic [LANES-1:0]        tmpWrEn
);
  localparam logic [DST_W-1:0] OUT_LIM = DST_W'(OUT_REGS);
  localparam logic [DST_W-1:0] TMP_LIM = DST_W'(OUT_REGS + TMP_REGS);

  logic [DESC_W-1:0] descTab [DEPTH];
  logic [DESC_W-1:0] curDesc;

  // Descriptor table: cleared by reset, one write port, asynchronous read
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < DEPTH; k++) descTab[k] <= '0;
    end else if (descWrEn) begin
      descTab[descWrAddr] <= descWrData;
    end
  end

  assign curDesc = descTab[descId];

  // Unpack descriptor fields into the strobe struct
  always_comb begin
    strobe.laneMask = curDesc[LANES-1:0];
    for (int s = 0; s < NSRC; s++) begin
      strobe.negate[s] = curDesc[LANES + s*FLD_W];
      for (int i = 0; i < LANES; i++)
        strobe.laneSel[s][i] = curDesc[LANES + s*FLD_W + 1 + i*SEL_W +: SEL_W];
    end
  end

  // Relative addressing
  logic signed [OFF_W-1:0] offVal;
  logic [IDX_W-1:0]        offIdx;

  always_comb begin
    unique case (addrRegSel)
      2'd0:    offVal = '0;
      2'd1:    offVal = addrReg0;
      2'd2:    offVal = addrReg1;
      default: offVal = loopCount;
    endcase
  end

  assign offIdx     = IDX_W'(offVal);
  assign src1IdxEff = src1Idx + (invertedEnc ? '0 : offIdx);
  assign src2IdxEff = src2Idx + (invertedEnc ? offIdx : '0);

  // Destination decode
  logic dstIsOut, dstIsTmp;
  assign dstIsOut = (dstIdx < OUT_LIM);
  assign dstIsTmp = !dstIsOut && (dstIdx < TMP_LIM);
  assign outWrEn  = dstIsOut ? strobe.laneMask : '0;
  assign tmpWrEn  = dstIsTmp ? strobe.laneMask : '0;
  assign dstReg   = REG_W'(dstIsTmp ? (dstIdx - OUT_LIM) : dstIdx);

  assert_mask_gate_R4: assert property (@(posedge clk) disable iff (!rstN)
    ((outWrEn | tmpWrEn) & ~strobe.laneMask) == '0);

  assert_one_file_R5: assert property (@(posedge clk) disable iff (!rstN)
    !((|outWrEn) && (|tmpWrEn)));

  assert_discard_R5: assert property (@(posedge clk) disable iff (!rstN)
    (dstIdx >= TMP_LIM) |-> (outWrEn == '0 && tmpWrEn == '0));

  assert_no_offset_R6: assert property (@(posedge clk) disable iff (!rstN)
    (addrRegSel == 2'd0) |-> (src1IdxEff == src1Idx && src2IdxEff == src2Idx));

  assert_inv_first_R7: assert property (@(posedge clk) disable iff (!rstN)
    invertedEnc |-> (src1IdxEff == src1Idx));

  assert_norm_second_R7: assert property (@(posedge clk) disable iff (!rstN)
    !invertedEnc |-> (src2IdxEff == src2Idx));

  assert_table_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    descWrEn |=> (descTab[$past(descWrAddr)] == $past(descWrData)));
endmodule

// File: rtl/swzDatapath.sv
module swzDatapath
  import swzPkg::*;
#(
  parameter int DATA_W  = 24,
  localparam int VEC_W  = LANES * DATA_W,
  localparam int BUS_W  = NSRC * VEC_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  swzStrobe_t        strobe,
  input  logic [BUS_W-1:0]  srcData,
  output logic [BUS_W-1:0]  srcOut
);
  function automatic logic [LANES*SEL_W-1:0] identSel();
    logic [LANES*SEL_W-1:0] r;
    for (int i = 0; i < LANES; i++) r[i*SEL_W +: SEL_W] = SEL_W'(i);
    return r;
  endfunction

  function automatic logic [VEC_W-1:0] signPattern();
    logic [VEC_W-1:0] r;
    r = '0;
    for (int i = 0; i < LANES; i++) r[i*DATA_W + DATA_W-1] = 1'b1;
    return r;
  endfunction

  localparam logic [LANES*SEL_W-1:0] IDENT = identSel();
  localparam logic [VEC_W-1:0]       SIGNS = signPattern();

  for (genvar s = 0; s < NSRC; s++) begin : gSrc
    for (genvar i = 0; i < LANES; i++) begin : gLane
      logic [DATA_W-1:0] picked;
      assign picked = srcData[(s*LANES + int'(strobe.laneSel[s][i]))*DATA_W +: DATA_W];
      assign srcOut[(s*LANES + i)*DATA_W +: DATA_W] =
        {picked[DATA_W-1] ^ strobe.negate[s], picked[DATA_W-2:0]};
    end

    assert_identity_R1: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.laneSel[s] == IDENT && !strobe.negate[s])
        |-> (srcOut[s*VEC_W +: VEC_W] == srcData[s*VEC_W +: VEC_W]));

    assert_negate_R2: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.laneSel[s] == IDENT && strobe.negate[s])
        |-> ((srcOut[s*VEC_W +: VEC_W] ^ srcData[s*VEC_W +: VEC_W]) == SIGNS));
  end
endmodule

// File: rtl/swzOperandUnit.sv
module swzOperandUnit
  import swzPkg::*;
#(
  parameter int DATA_W   = 24,
  parameter int DEPTH    = 128,
  parameter int IDX_W    = 7,
  parameter int OFF_W    = 8,
  parameter int DST_W    = 7,
  parameter int OUT_REGS = 16,
  parameter int TMP_REGS = 16,
  localparam int AW      = $clog2(DEPTH),
  localparam int REG_W   = $clog2(OUT_REGS),
  localparam int BUS_W   = NSRC * LANES * DATA_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    descWrEn,
  input  logic [AW-1:0]           descWrAddr,
  input  logic [DESC_W-1:0]       descWrData,
  input  logic [AW-1:0]           descId,
  input  logic                    invertedEnc,
  input  logic [1:0]              addrRegSel,
  input  logic signed [OFF_W-1:0] addrReg0,
  input  logic signed [OFF_W-1:0] addrReg1,
  input  logic signed [OFF_W-1:0] loopCount,
  input  logic [IDX_W-1:0]        src1Idx,
  input  logic [IDX_W-1:0]        src2Idx,
  input  logic [DST_W-1:0]        dstIdx,
  input  logic [BUS_W-1:0]        srcData,
  output logic [IDX_W-1:0]        src1IdxEff,
  output logic [IDX_W-1:0]        src2IdxEff,
  output logic [BUS_W-1:0]        srcOut,
  output logic [REG_W-1:0]        dstReg,
  output logic [LANES-1:0]        outWrEn,
  output logic [LANES-1:0]        tmpWrEn
);
  swzStrobe_t strobe;

  swzCtrl #(
    .DEPTH(DEPTH), .IDX_W(IDX_W), .OFF_W(OFF_W), .DST_W(DST_W),
    .OUT_REGS(OUT_REGS), .TMP_REGS(TMP_REGS)
  ) uCtrl (
    .clk(clk), .rstN(rstN),
    .descWrEn(descWrEn), .descWrAddr(descWrAddr), .descWrData(descWrData),
    .descId(descId), .invertedEnc(invertedEnc), .addrRegSel(addrRegSel),
    .addrReg0(addrReg0), .addrReg1(addrReg1), .loopCount(loopCount),
    .src1Idx(src1Idx), .src2Idx(src2Idx), .dstIdx(dstIdx),
    .strobe(strobe), .src1IdxEff(src1IdxEff), .src2IdxEff(src2IdxEff),
    .dstReg(dstReg), .outWrEn(outWrEn), .tmpWrEn(tmpWrEn)
  );

  swzDatapath #(.DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .srcData(srcData), .srcOut(srcOut)
  );
endmodule

// File: tb/sim_swzOperandUnit.sv
`timescale 1ns/1ps
module sim_swzOperandUnit;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         descWrEn = 1'b0;
  logic [6:0]   descWrAddr = '0;
  logic [30:0]  descWrData = '0;
  logic [6:0]   descId = '0;
  logic         invertedEnc = 1'b0;
  logic [1:0]   addrRegSel = '0;
  logic signed [7:0] addrReg0 = 8'sd5;
  logic signed [7:0] addrReg1 = -8'sd3;
  logic signed [7:0] loopCount = 8'sd100;
  logic [6:0]   src1Idx = '0, src2Idx = '0, dstIdx = '0;
  logic [287:0] srcData = '0;
  logic [6:0]   src1IdxEff, src2IdxEff;
  logic [287:0] srcOut;
  logic [3:0]   dstReg, outWrEn, tmpWrEn;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  swzOperandUnit u0 (
    .clk(clk), .rstN(rstN), .descWrEn(descWrEn), .descWrAddr(descWrAddr),
    .descWrData(descWrData), .descId(descId), .invertedEnc(invertedEnc),
    .addrRegSel(addrRegSel), .addrReg0(addrReg0), .addrReg1(addrReg1),
    .loopCount(loopCount), .src1Idx(src1Idx), .src2Idx(src2Idx), .dstIdx(dstIdx),
    .srcData(srcData), .src1IdxEff(src1IdxEff), .src2IdxEff(src2IdxEff),
    .srcOut(srcOut), .dstReg(dstReg), .outWrEn(outWrEn), .tmpWrEn(tmpWrEn)
  );

  task automatic check(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] mix(input int k);
    logic [31:0] h;
    h = 32'(k) * 32'h9E3779B1 + 32'h7F4A7C15;
    return h[31:8] ^ h[23:0];
  endfunction

  function automatic logic [95:0] expSrc(input logic [287:0] d, input int s,
                                          input logic [7:0] sel, input bit neg);
    logic [95:0] r;
    for (int i = 0; i < 4; i++) begin
      logic [23:0] v;
      v = d[(s*4 + int'(sel[2*i +: 2]))*24 +: 24];
      if (neg) v[23] = ~v[23];
      r[i*24 +: 24] = v;
    end
    return r;
  endfunction

  function automatic logic [30:0] mkDesc(input logic [7:0] s0, input bit n0,
      input logic [7:0] s1, input bit n1, input logic [7:0] s2, input bit n2,
      input logic [3:0] mask);
    return {s2, n2, s1, n1, s0, n0, mask};
  endfunction

  task automatic writeDesc(input logic [6:0] id, input logic [30:0] d);
    @(negedge clk);
    descWrEn = 1'b1; descWrAddr = id; descWrData = d;
    @(negedge clk);
    descWrEn = 1'b0;
  endtask

  task automatic fillData(input int seed);
    for (int k = 0; k < 12; k++) srcData[k*24 +: 24] = mix(seed * 16 + k);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    logic [30:0] dKeep;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R9: reset state of table
    fillData(7);
    descId = 7'd77; dstIdx = 7'd3;
    #1;
    check(outWrEn == 4'h0 && tmpWrEn == 4'h0, "R9 reset mask", {92'b0, outWrEn}, 96'h0);
    check(srcOut[95:0] == expSrc(srcData, 0, 8'h00, 1'b0), "R9 reset broadcast x",
          srcOut[95:0], expSrc(srcData, 0, 8'h00, 1'b0));

    // R1 R2 R3 R4: selector sweep
    for (int p = 0; p < 256; p++) begin
      logic [7:0] s0, s1, s2;
      bit n0, n1, n2;
      logic [3:0] m;
      s0 = 8'(p); s1 = 8'(p) ^ 8'hA5; s2 = {s0[3:0], s0[7:4]};
      n0 = s0[5]; n1 = s0[6] ^ s0[0]; n2 = s0[7];
      m  = s0[3:0] ^ s0[7:4];
      writeDesc(7'(p), mkDesc(s0, n0, s1, n1, s2, n2, m));
      fillData(p);
      descId = 7'(p); dstIdx = 7'(p & 31);
      #1;
      check(srcOut[95:0] == expSrc(srcData, 0, s0, n0), "R1/R2 source0",
            srcOut[95:0], expSrc(srcData, 0, s0, n0));
      check(srcOut[191:96] == expSrc(srcData, 1, s1, n1), "R3 source1",
            srcOut[191:96], expSrc(srcData, 1, s1, n1));
      check(srcOut[287:192] == expSrc(srcData, 2, s2, n2), "R3 source2",
            srcOut[287:192], expSrc(srcData, 2, s2, n2));
      check((outWrEn | tmpWrEn) == m, "R4 lane mask", {92'b0, outWrEn | tmpWrEn}, {92'b0, m});
    end

    // R5: destination decode over all indices
    writeDesc(7'd1, mkDesc(8'hE4, 1'b0, 8'hE4, 1'b0, 8'hE4, 1'b0, 4'b1011));
    descId = 7'd1;
    for (int d = 0; d < 128; d++) begin
      logic [3:0] eo, et, er;
      dstIdx = 7'(d);
      eo = (d < 16) ? 4'b1011 : 4'h0;
      et = (d >= 16 && d < 32) ? 4'b1011 : 4'h0;
      er = 4'(d);
      #1;
      check(outWrEn == eo && tmpWrEn == et, "R5 dest file",
            {88'b0, outWrEn, tmpWrEn}, {88'b0, eo, et});
      if (d < 32)
        check(dstReg == er, "R5 dest register", {92'b0, dstReg}, {92'b0, er});
    end

    // R6 R7: offset sources under both encodings
    for (int sel = 0; sel < 4; sel++) begin
      for (int inv = 0; inv < 2; inv++) begin
        for (int q = 0; q < 3; q++) begin
          int off, i1, i2, e1, e2;
          off = (sel == 0) ? 0 : (sel == 1) ? 5 : (sel == 2) ? -3 : 100;
          i1 = (q == 0) ? 0 : (q == 1) ? 127 : 60;
          i2 = i1 ^ 42;
          e1 = inv ? i1 : ((i1 + off) & 127);
          e2 = inv ? ((i2 + off) & 127) : i2;
          @(negedge clk);
          addrRegSel = 2'(sel); invertedEnc = inv[0];
          src1Idx = 7'(i1); src2Idx = 7'(i2);
          #1;
          check(src1IdxEff == 7'(e1), "R6/R7 first index", {89'b0, src1IdxEff}, 96'(e1));
          check(src2IdxEff == 7'(e2), "R6/R7 second index", {89'b0, src2IdxEff}, 96'(e2));
        end
      end
    end

    // R8: table write, ignored strobe, neighbour isolation
    dKeep = mkDesc(8'h1B, 1'b1, 8'h4E, 1'b0, 8'hB1, 1'b1, 4'b0110);
    writeDesc(7'd9, dKeep);
    @(negedge clk);
    descWrAddr = 7'd9; descWrData = mkDesc(8'h00, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 4'hF);
    @(negedge clk);
    writeDesc(7'd10, mkDesc(8'hFF, 1'b1, 8'hFF, 1'b1, 8'hFF, 1'b1, 4'h1));
    fillData(999);
    descId = 7'd9; dstIdx = 7'd20;
    #1;
    check(tmpWrEn == 4'b0110, "R8 entry kept", {92'b0, tmpWrEn}, {92'b0, 4'b0110});
    check(srcOut[95:0] == expSrc(srcData, 0, 8'h1B, 1'b1), "R8 entry selectors",
          srcOut[95:0], expSrc(srcData, 0, 8'h1B, 1'b1));
    descId = 7'd10;
    #1;
    check(tmpWrEn == 4'b0001, "R8 neighbour written", {92'b0, tmpWrEn}, {92'b0, 4'b0001});

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule